// File: doc/BRIEF.md
# Performance Monitor Alert Controller

This block holds the control bits of a performance monitor that decide what happens when a counter overflows. Those bits are the global counter freeze, freeze-on-alert, alert enable, the sticky alert-occurred flag and a two-bit branch-history filter mode. Software loads all six bits at once through a write strobe. The counter bank signals an overflow with a single-cycle alert pulse.

On an alert, the block may freeze every counter. It turns an armed alert enable into a sticky occurred flag and raises a level performance-monitor interrupt. It also issues a one-cycle request for an event-based branch exception. A one-hot branch-type mask is derived from the enable bit and the filter mode, and the branch-history recorder uses that mask to decide which branches to keep.

The interrupt line is produced by a two-state machine. `IRQ_IDLE` means the line is low and `IRQ_RAISED` means it is high. A software write moves the machine to the state that matches the written occurred bit, so a 1 goes to `IRQ_RAISED` and a 0 goes to `IRQ_IDLE`. An alert taken while enabled moves it to `IRQ_RAISED`. With no write and no taken alert, the machine stays where it is.

Top module: `pm_alert_ctrl`

## Requirements
- R1: An alert seen while freeze-on-alert (bit 1) is 1 sets the freeze bit (bit 0), and `freeze_o` is high from the next cycle. An alert seen with freeze-on-alert at 0 leaves the freeze bit unchanged.
- R2: An alert seen while alert enable (bit 2) is 1 clears alert enable and sets alert-occurred (bit 3) in the next cycle, and `pm_irq` is high from that cycle on.
- R3: After a software write with no alert in the same cycle, `pm_irq` in the next cycle equals the written alert-occurred bit (bit 3 of `ctl_wdata`).
- R4: Every alert produces `ebb_req` high for exactly the following cycle. `ebb_req` is low in every other cycle.
- R5: While alert enable is 0, `bhrb_mask` is 3'b000 (record nothing).
- R6: While alert enable is 1, the mode field (bits 5:4) selects `bhrb_mask`, where bit 0 is calls, bit 1 is indirect and bit 2 is conditional. Mode 0 gives 3'b111 (all branches), mode 1 gives 3'b001, mode 2 gives 3'b010 and mode 3 gives 3'b100.
- R7: When a write and an alert fall in the same cycle, the written value is applied first and the alert then acts on it, using the written freeze-on-alert and alert-enable bits.
- R8: In a cycle with neither a write nor an alert, all control bits and `pm_irq` keep their values. An alert with alert enable at 0 leaves alert enable, alert-occurred and `pm_irq` unchanged.
- R9: After reset, all control bits are 0, and `pm_irq`, `ebb_req`, `freeze_o` and `bhrb_mask` are 0.
- R10: A write replaces all six control bits. `ctl_q` shows them in the layout {mode[1:0], occurred, enable, freeze-on-alert, freeze}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Software write strobe for the control bits |
| ctl_wdata | input | 6 | Value to write: {mode, occurred, enable, freeze-on-alert, freeze} |
| alert_i | input | 1 | One-cycle overflow alert from the counter bank |
| ctl_q | output | 6 | Current control bits, same layout as `ctl_wdata` |
| freeze_o | output | 1 | Global freeze sent to the counter bank |
| pm_irq | output | 1 | Level performance-monitor interrupt |
| ebb_req | output | 1 | One-cycle event-based branch exception request |
| bhrb_mask | output | 3 | Branch types to record: {conditional, indirect, call} |

## Verification
A software write and an overflow alert can arrive in the same cycle. The order in which they are resolved then decides freeze, enable, occurred and the interrupt. The bench raises `ctl_wr` and `alert_i` together, once in directed cases and many times in a random phase. These cases cover written enable and freeze-on-alert both set and both cleared, and a written occurred bit of 0 that the alert overrides. A behavioural model applies the written value and then the alert, and each cycle the bench compares its result with `ctl_q`, `pm_irq` and `ebb_req`.

// File: rtl/pm_alert_pkg.sv
package pm_alert_pkg;

    localparam int MODE_W = 2;
    localparam int MASK_W = 3;
    localparam int CTL_W  = MODE_W + 4;

    // mask bit positions
    localparam int MB_CALL = 0;
    localparam int MB_IND  = 1;
    localparam int MB_COND = 2;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              occurred;
        logic              enable;
        logic              frz_on_alert;
        logic              freeze;
    } ctl_t;

    typedef enum logic [0:0] {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_st_t;

endpackage

// File: rtl/pm_alert_ctlreg.sv
module pm_alert_ctlreg
    import pm_alert_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CTL_W-1:0] wdata_i,
    input  logic             alert_i,
    output ctl_t             ctl_o,
    output logic             taken_o,
    output logic             ebb_o
);

    ctl_t ctl_q;
    ctl_t ctl_n;
    ctl_t wr_view;
    logic ebb_q;

    assign wr_view = ctl_t'(wdata_i);

    // write first, then alert modifications
    always_comb begin
        ctl_n   = ctl_q;
        taken_o = 1'b0;
        if (wr_i) begin
            ctl_n = wr_view;
        end
        if (alert_i) begin
            if (ctl_n.frz_on_alert) begin
                ctl_n.freeze = 1'b1;
            end
            if (ctl_n.enable) begin
                ctl_n.enable   = 1'b0;
                ctl_n.occurred = 1'b1;
                taken_o        = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            ebb_q <= 1'b0;
        end else begin
            ctl_q <= ctl_n;
            ebb_q <= alert_i;
        end
    end

    assign ctl_o = ctl_q;
    assign ebb_o = ebb_q;

    AST_FREEZE_ON_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_i && !wr_i && ctl_q.frz_on_alert) |=> ctl_q.freeze); // R1
    AST_ENABLE_TO_OCCURRED: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_i && !wr_i && ctl_q.enable) |=> (!ctl_q.enable && ctl_q.occurred)); // R2
    AST_EBB_AFTER_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
        alert_i |=> ebb_q); // R4
    AST_EBB_ONLY_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
        !alert_i |=> !ebb_q); // R4
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!alert_i && !wr_i) |=> $stable(ctl_q)); // R8

endmodule

// File: rtl/pm_alert_irq_fsm.sv
module pm_alert_irq_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic wr_occ_i,
    input  logic taken_i,
    output logic irq_o
);
    import pm_alert_pkg::*;

    irq_st_t st_q;
    irq_st_t st_n;

    always_comb begin
        st_n = st_q;
        if (wr_i) begin
            st_n = wr_occ_i ? IRQ_RAISED : IRQ_IDLE;
        end
        if (taken_i) begin
            st_n = IRQ_RAISED;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= IRQ_IDLE;
        else        st_q <= st_n;
    end

    always_comb begin
        unique case (st_q)
            IRQ_IDLE:   irq_o = 1'b0;
            IRQ_RAISED: irq_o = 1'b1;
        endcase
    end

    AST_IRQ_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !taken_i) |=> (irq_o == $past(wr_occ_i))); // R3
    AST_IRQ_ON_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        taken_i |=> irq_o); // R2

endmodule

// File: rtl/pm_alert_filter.sv
module pm_alert_filter
    import pm_alert_pkg::*;
(
    input  logic              enable_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic [MASK_W-1:0] mask_o
);

    always_comb begin
        mask_o = '0;
        if (enable_i) begin
            unique case (mode_i)
                2'd0: mask_o = '1;
                2'd1: mask_o[MB_CALL] = 1'b1;
                2'd2: mask_o[MB_IND]  = 1'b1;
                2'd3: mask_o[MB_COND] = 1'b1;
            endcase
        end
    end

    always_comb begin
        if (enable_i && mode_i != '0) begin
            AST_MASK_ONE_TYPE: assert ($onehot(mask_o)); // R6
        end
    end

endmodule

// File: rtl/pm_alert_ctrl.sv
module pm_alert_ctrl
    import pm_alert_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             alert_i,
    output logic [CTL_W-1:0] ctl_q,
    output logic             freeze_o,
    output logic             pm_irq,
    output logic             ebb_req,
    output logic [MASK_W-1:0] bhrb_mask
);

    ctl_t ctl;
    logic taken;
    ctl_t wr_view;

    assign wr_view = ctl_t'(ctl_wdata);

    pm_alert_ctlreg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctl_wr),
        .wdata_i (ctl_wdata),
        .alert_i (alert_i),
        .ctl_o   (ctl),
        .taken_o (taken),
        .ebb_o   (ebb_req)
    );

    pm_alert_irq_fsm u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (ctl_wr),
        .wr_occ_i (wr_view.occurred),
        .taken_i  (taken),
        .irq_o    (pm_irq)
    );

    pm_alert_filter u_flt (
        .enable_i (ctl.enable),
        .mode_i   (ctl.mode),
        .mask_o   (bhrb_mask)
    );

    assign ctl_q    = ctl;
    assign freeze_o = ctl.freeze;

    AST_FILTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.enable |-> (bhrb_mask == '0)); // R5
    AST_IRQ_MATCHES_OCC: assert property (@(posedge clk) disable iff (!rst_n)
        pm_irq == ctl.occurred); // R3

endmodule

// File: tb/sim_pm_alert_ctrl.sv
module sim_pm_alert_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [5:0] ctl_wdata = '0;
    logic       alert_i = 1'b0;
    logic [5:0] ctl_q;
    logic       freeze_o;
    logic       pm_irq;
    logic       ebb_req;
    logic [2:0] bhrb_mask;

    int checks = 0;
    int failures = 0;
    string tag = "R9";

    // reference model state
    int m_frz = 0, m_fce = 0, m_en = 0, m_occ = 0, m_mode = 0, m_irq = 0, m_ebb = 0;

    always #10 clk = ~clk;

    pm_alert_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .alert_i(alert_i), .ctl_q(ctl_q), .freeze_o(freeze_o),
        .pm_irq(pm_irq), .ebb_req(ebb_req), .bhrb_mask(bhrb_mask)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_frz = 0; m_fce = 0; m_en = 0; m_occ = 0; m_mode = 0; m_irq = 0; m_ebb = 0;
        end else begin
            if (ctl_wr) begin
                m_frz  = ctl_wdata[0];
                m_fce  = ctl_wdata[1];
                m_en   = ctl_wdata[2];
                m_occ  = ctl_wdata[3];
                m_mode = ctl_wdata[5:4];
                m_irq  = m_occ;
            end
            m_ebb = alert_i;
            if (alert_i) begin
                if (m_fce != 0) m_frz = 1;
                if (m_en != 0) begin
                    m_en = 0; m_occ = 1; m_irq = 1;
                end
            end
        end
    end

    function automatic int exp_mask();
        if (m_en == 0) return 0;
        case (m_mode)
            0: return 7;
            1: return 1;
            2: return 2;
            default: return 4;
        endcase
    endfunction

    task automatic chk(string t, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s got=%0d expected=%0d", t, what, got, exp);
        end
    endtask

    task automatic compare_all();
        int exp_ctl;
        exp_ctl = (m_mode << 4) | (m_occ << 3) | (m_en << 2) | (m_fce << 1) | m_frz;
        chk(tag, "ctl_q", int'(ctl_q), exp_ctl);
        chk(tag, "freeze_o", int'(freeze_o), m_frz);
        chk(tag, "pm_irq", int'(pm_irq), m_irq);
        chk(tag, "ebb_req", int'(ebb_req), m_ebb);
        chk((m_en != 0) ? "R6" : "R5", "bhrb_mask", int'(bhrb_mask), exp_mask());
    endtask

    // one cycle: compare at falling edge, then drive next inputs
    task automatic cyc(bit wr, logic [5:0] wd, bit al);
        @(negedge clk);
        compare_all();
        ctl_wr = wr; ctl_wdata = wd; alert_i = al;
    endtask

    task automatic settle();
        cyc(0, 6'd0, 0);
        cyc(0, 6'd0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R9";
        settle();
        // R10: write replaces every field, readback layout
        tag = "R10";
        cyc(1, 6'b10_0_0_1_1, 0);
        settle();
        cyc(1, 6'b01_0_1_0_0, 0);
        settle();
        // R6: each filter mode with enable set
        tag = "R6";
        for (int m = 0; m < 4; m++) begin
            cyc(1, 6'((m << 4) | 4), 0);
            cyc(0, 6'd0, 0);
        end
        // R5: enable clear, all modes
        tag = "R5";
        for (int m = 0; m < 4; m++) begin
            cyc(1, 6'(m << 4), 0);
            cyc(0, 6'd0, 0);
        end
        // R1: alert with freeze-on-alert, no enable
        tag = "R1";
        cyc(1, 6'b00_0_0_1_0, 0);
        cyc(0, 6'd0, 1);
        settle();
        // R1/R8: alert without freeze-on-alert keeps freeze 0
        tag = "R8";
        cyc(1, 6'b00_0_0_0_0, 0);
        cyc(0, 6'd0, 1);
        settle();
        // R2: alert while enabled
        tag = "R2";
        cyc(1, 6'b11_0_1_0_0, 0);
        cyc(0, 6'd0, 1);
        settle();
        // R4: back-to-back alerts
        tag = "R4";
        cyc(0, 6'd0, 1);
        cyc(0, 6'd0, 1);
        cyc(0, 6'd0, 0);
        settle();
        // R3: write clears occurred, then sets it
        tag = "R3";
        cyc(1, 6'b00_0_0_0_0, 0);
        settle();
        cyc(1, 6'b00_1_0_0_0, 0);
        settle();
        cyc(1, 6'b00_0_0_0_0, 0);
        settle();
        // R7: write and alert together
        tag = "R7";
        cyc(1, 6'b10_0_1_1_0, 1);
        settle();
        cyc(1, 6'b00_0_0_0_0, 1);
        settle();
        cyc(1, 6'b01_0_1_0_0, 1);
        settle();
        // random mix
        tag = "R7";
        for (int i = 0; i < 400; i++) begin
            cyc(($urandom % 3) == 0, 6'($urandom), ($urandom % 4) == 0);
        end
        tag = "R9";
        rst_n = 1'b0;
        cyc(0, 6'd0, 0);
        rst_n = 1'b1;
        settle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule